// File: doc/BRIEF.md
# Register-Cached Parameter Stack Unit

This block is the data stack of a small stack-oriented processor. The two uppermost entries sit in dedicated registers, called TOP and NEXT here, and are visible to an ALU at all times. Every entry below them lives in a 64-word stack RAM addressed by an internal pointer. A command that grows the stack writes the old NEXT into the RAM. A command that shrinks it refills NEXT from the RAM location just below the pointer. The RAM write and the register update happen on the same clock edge.

One decoded command is accepted per cycle on a 3-bit opcode. An independent invert bit can ones-complement the TOP value that the command produces. Short literals arrive on a 5-bit field, long literals on a full-word input, and bus or memory read data on a separate load input. Two sticky flags report a push into a full RAM and a pop from an empty RAM.

Top module: `pstk_unit`

## Requirements
- R1: While rst_n is low at a rising edge, TOP, NEXT, the stack pointer and both flags are cleared to zero.
- R2: Opcode 0 (hold) with the invert bit at 0 leaves TOP, NEXT, the pointer and the flags unchanged, whatever the data inputs carry.
- R3: Opcode 1 (exchange) swaps TOP and NEXT and leaves the RAM and the pointer unchanged.
- R4: Opcode 2 (duplicate) copies TOP into NEXT and pushes the old NEXT into the RAM.
- R5: Opcode 3 (over) moves the old NEXT to TOP and the old TOP to NEXT, and pushes the old NEXT into the RAM.
- R6: Opcode 4 (drop) discards TOP, moves NEXT to TOP and refills NEXT from the most recently pushed RAM word, in last-in first-out order.
- R7: Opcode 5 (short literal) zero-extends the 5-bit field (0 to 31) into TOP, moves the old TOP to NEXT and pushes the old NEXT.
- R8: Opcode 6 (long literal) loads the full word input into TOP, with the same push effect as R7. The 5-bit field is ignored.
- R9: Opcode 7 (load) writes the load word into TOP and changes neither NEXT nor the depth.
- R10: With the invert bit at 1, the TOP value produced by the command, including hold, is replaced by its ones complement.
- R11: A push while the RAM holds 64 words sets the overflow flag. The registers still update, the spilled word is discarded, and the RAM and pointer keep their contents.
- R12: A drop while the RAM is empty sets the underflow flag, loads NEXT with zero and leaves the pointer at zero.
- R13: Both flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Stack command opcode |
| cmd_inv | input | 1 | Complement the resulting TOP |
| short_lit | input | 5 | Short literal value |
| long_lit | input | 16 | Long literal word |
| load_word | input | 16 | Read data for the load command |
| top_o | output | 16 | Current TOP register |
| next_o | output | 16 | Current NEXT register |
| overflow_o | output | 1 | Sticky push-when-full flag |
| underflow_o | output | 1 | Sticky pop-when-empty flag |

## Verification
Every result is due one rising edge after the command is presented. TOP, NEXT and both flags are registered, and the RAM write lands on the same edge. The bench drives each command just after a falling edge and checks the outputs at the following falling edge, half a period after the updating edge. RAM contents and depth are observed only through later drop commands, which bring the stored words back into NEXT one edge each.

// File: rtl/pstk_pkg.sv
// Package: shared opcode type for the parameter stack unit.
// Assumes a 3-bit command opcode whose encoding the decoder upstream matches.
package pstk_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_EXCH  = 3'd1,
        OP_DUPL  = 3'd2,
        OP_OVER  = 3'd3,
        OP_DROP  = 3'd4,
        OP_SLIT  = 3'd5,
        OP_LLIT  = 3'd6,
        OP_LOAD  = 3'd7
    } stk_op_e;
endpackage

// File: rtl/pstk_ram.sv
// Stack RAM: one write port and one asynchronous read port.
// Assumes the pointer logic never issues a write to an invalid address.
module pstk_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a spilled word on a granted push.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word just below the pointer for refills.
    assign rdata = mem[raddr];
endmodule

// File: rtl/pstk_ptr.sv
// Pointer and flags: counts the words held in the stack RAM, grants
// writes and refills, and keeps the sticky overflow and underflow flags.
// Assumes push and pop are never requested together.
module pstk_ptr #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          ram_we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          overflow,
    output logic          underflow
);
    logic [AW:0] count;
    logic        full;

    assign full   = (count == (AW+1)'(DEPTH));
    assign empty  = (count == '0);
    assign ram_we = push && !full;
    assign waddr  = count[AW-1:0];
    assign raddr  = count[AW-1:0] - AW'(1);

    // Advance or retreat the word count on granted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (push && !full)    count <= count + 1'b1;
        else if (pop && !empty)    count <= count - 1'b1;
    end

    // Latch the error flags until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (push && full)  overflow  <= 1'b1;
            if (pop && empty)  underflow <= 1'b1;
        end
    end

    assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (count == $past(count) + 1'b1));
    assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (count == $past(count) - 1'b1));
    assert_no_overflow_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (overflow && $stable(count)));
    assert_underflow_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (underflow && count == '0));
    assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |=> ((overflow >= $past(overflow)) && (underflow >= $past(underflow))));
endmodule

// File: rtl/pstk_cache.sv
// Register cache: holds TOP and NEXT, applies each decoded command and
// the optional complement, and requests pushes and pops from the pointer.
// Assumes fill_word already reads zero when the RAM is empty.
module pstk_cache
    import pstk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SLW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    input  logic             inv,
    input  logic [SLW-1:0]   short_lit,
    input  logic [WIDTH-1:0] long_lit,
    input  logic [WIDTH-1:0] load_word,
    input  logic [WIDTH-1:0] fill_word,
    output logic             push,
    output logic             pop,
    output logic [WIDTH-1:0] spill_word,
    output logic [WIDTH-1:0] top_q,
    output logic [WIDTH-1:0] next_q
);
    logic [WIDTH-1:0] top_d, top_pre, next_d;

    // Decode the command into next TOP/NEXT values and stack motion.
    always_comb begin
        top_pre = top_q;
        next_d  = next_q;
        push    = 1'b0;
        pop     = 1'b0;
        unique case (op)
            OP_HOLD: ;
            OP_EXCH: begin top_pre = next_q; next_d = top_q; end
            OP_DUPL: begin next_d = top_q; push = 1'b1; end
            OP_OVER: begin top_pre = next_q; next_d = top_q; push = 1'b1; end
            OP_DROP: begin top_pre = next_q; next_d = fill_word; pop = 1'b1; end
            OP_SLIT: begin top_pre = WIDTH'(short_lit); next_d = top_q; push = 1'b1; end
            OP_LLIT: begin top_pre = long_lit; next_d = top_q; push = 1'b1; end
            OP_LOAD: top_pre = load_word;
            default: ;
        endcase
        top_d = inv ? ~top_pre : top_pre;
    end

    assign spill_word = next_q;

    // Register the cached entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q  <= '0;
            next_q <= '0;
        end else begin
            top_q  <= top_d;
            next_q <= next_d;
        end
    end

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD && !inv) |=> ($stable(top_q) && $stable(next_q)));
    assert_exchange_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EXCH && !inv) |=> (top_q == $past(next_q) && next_q == $past(top_q)));
    assert_load_keeps_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (next_q == $past(next_q)));
    assert_one_motion_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/pstk_unit.sv
// Top: parameter stack with TOP/NEXT cached in registers and deeper
// entries in a stack RAM. One command per cycle; results one edge later.
// Assumes the opcode follows pstk_pkg::stk_op_e.
module pstk_unit
    import pstk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    parameter int SLW   = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_inv,
    input  logic [SLW-1:0]   short_lit,
    input  logic [WIDTH-1:0] long_lit,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] next_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    logic             push, pop, ram_we, empty;
    logic [AW-1:0]    waddr, raddr;
    logic [WIDTH-1:0] spill_word, rdata, fill_word;

    // Empty RAM refills NEXT with zero.
    assign fill_word = empty ? '0 : rdata;

    pstk_cache #(.WIDTH(WIDTH), .SLW(SLW)) u_cache (
        .clk(clk), .rst_n(rst_n), .op(stk_op_e'(cmd_op)), .inv(cmd_inv),
        .short_lit(short_lit), .long_lit(long_lit), .load_word(load_word),
        .fill_word(fill_word), .push(push), .pop(pop), .spill_word(spill_word),
        .top_q(top_o), .next_q(next_o)
    );

    pstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .ram_we(ram_we),
        .waddr(waddr), .raddr(raddr), .empty(empty),
        .overflow(overflow_o), .underflow(underflow_o)
    );

    pstk_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(waddr), .wdata(spill_word),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: tb/pstk_unit_bench.sv
// Directed bench for pstk_unit: one task per scenario, checks at falling edges.
module pstk_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cmd_op;
    logic        cmd_inv;
    logic [4:0]  short_lit;
    logic [15:0] long_lit, load_word;
    logic [15:0] top_o, next_o;
    logic        overflow_o, underflow_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pstk_unit u_pstk_unit (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_inv(cmd_inv),
        .short_lit(short_lit), .long_lit(long_lit), .load_word(load_word),
        .top_o(top_o), .next_o(next_o),
        .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one command after a falling edge; return at the next falling edge.
    task automatic cmd(input logic [2:0] op, input logic inv = 1'b0,
                       input logic [4:0] sl = 5'd0, input logic [15:0] ll = 16'h0,
                       input logic [15:0] lw = 16'h0);
        cmd_op = op; cmd_inv = inv; short_lit = sl; long_lit = ll; load_word = lw;
        @(negedge clk);
        cmd_op = 3'd0; cmd_inv = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_op = 3'd0; cmd_inv = 1'b0; short_lit = '0; long_lit = '0; load_word = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        cmd(3'd5, 1'b0, 5'd9);
        do_reset();
        chk("R1 top", top_o, 16'h0);
        chk("R1 next", next_o, 16'h0);
        chk("R1 flags", {14'h0, overflow_o, underflow_o}, 16'h0);
    endtask

    task automatic t_literals();
        do_reset();
        cmd(3'd5, 1'b0, 5'd5);
        cmd(3'd5, 1'b0, 5'd31);
        chk("R7 top zero-extended", top_o, 16'h001F);
        chk("R7 next", next_o, 16'h0005);
        cmd(3'd6, 1'b0, 5'd3, 16'hBEEF);
        chk("R8 top", top_o, 16'hBEEF);
        chk("R8 next", next_o, 16'h001F);
        cmd(3'd4);
        chk("R6 drop top", top_o, 16'h001F);
        chk("R6 drop next", next_o, 16'h0005);
        cmd(3'd4);
        cmd(3'd4);
        chk("R6 drained", {top_o, 15'h0, underflow_o} == {16'h0, 16'h0} ? 16'h0 : 16'h1, 16'h0);
        cmd(3'd4);
        chk("R12 underflow", {15'h0, underflow_o}, 16'h1);
        chk("R12 next zero", next_o, 16'h0);
        cmd(3'd5, 1'b0, 5'd2);
        cmd(3'd5, 1'b0, 5'd4);
        chk("R13 underflow sticky", {15'h0, underflow_o}, 16'h1);
    endtask

    task automatic t_swap();
        do_reset();
        cmd(3'd5, 1'b0, 5'd1); cmd(3'd5, 1'b0, 5'd2); cmd(3'd5, 1'b0, 5'd3);
        cmd(3'd1);
        chk("R3 top", top_o, 16'h2);
        chk("R3 next", next_o, 16'h3);
        cmd(3'd4);
        chk("R3 ram untouched", next_o, 16'h1);
    endtask

    task automatic t_dup();
        do_reset();
        cmd(3'd5, 1'b0, 5'd7); cmd(3'd5, 1'b0, 5'd9);
        cmd(3'd2);
        chk("R4 next", next_o, 16'h9);
        chk("R4 top", top_o, 16'h9);
        cmd(3'd4);
        chk("R4 spilled", next_o, 16'h7);
    endtask

    task automatic t_over();
        do_reset();
        cmd(3'd5, 1'b0, 5'd7); cmd(3'd5, 1'b0, 5'd9);
        cmd(3'd3);
        chk("R5 top", top_o, 16'h7);
        chk("R5 next", next_o, 16'h9);
        cmd(3'd4);
        chk("R5 pushed old next", next_o, 16'h7);
        cmd(3'd4);
        chk("R5 depth", next_o, 16'h0);
    endtask

    task automatic t_load();
        do_reset();
        cmd(3'd5, 1'b0, 5'd4); cmd(3'd5, 1'b0, 5'd6); cmd(3'd5, 1'b0, 5'd8);
        cmd(3'd7, 1'b0, 5'd0, 16'h0, 16'h1234);
        chk("R9 top", top_o, 16'h1234);
        chk("R9 next", next_o, 16'h6);
        cmd(3'd4);
        chk("R9 depth kept", next_o, 16'h4);
    endtask

    task automatic t_inv_hold();
        do_reset();
        cmd(3'd5, 1'b1, 5'd10);
        chk("R10 inverted literal", top_o, 16'hFFF5);
        cmd(3'd0, 1'b1);
        chk("R10 hold inverted", top_o, 16'h000A);
        cmd(3'd0, 1'b0, 5'd31, 16'hAAAA, 16'h5555);
        cmd(3'd0, 1'b0, 5'd17, 16'h1111, 16'h2222);
        chk("R2 hold top", top_o, 16'h000A);
        chk("R2 hold next", next_o, 16'h0);
        chk("R2 hold flags", {14'h0, overflow_o, underflow_o}, 16'h0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 1; k <= 64; k++) cmd(3'd5, 1'b0, 5'(k % 32));
        chk("R11 no flag at 64", {15'h0, overflow_o}, 16'h0);
        cmd(3'd5, 1'b0, 5'(65 % 32));
        chk("R11 overflow", {15'h0, overflow_o}, 16'h1);
        chk("R11 top", top_o, 16'(65 % 32));
        chk("R11 next", next_o, 16'(64 % 32));
        cmd(3'd4);
        chk("R11 ram kept", next_o, 16'(62 % 32));
        chk("R13 overflow sticky", {15'h0, overflow_o}, 16'h1);
        do_reset();
        chk("R1 flags cleared", {14'h0, overflow_o, underflow_o}, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_op = 3'd0; cmd_inv = 1'b0; short_lit = '0; long_lit = '0; load_word = '0;
        @(negedge clk);
        t_reset();
        t_literals();
        t_swap();
        t_dup();
        t_over();
        t_load();
        t_inv_hold();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule